// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects the interrupt requests of a small 8-bit microcontroller core and presents the CPU with a single request line and a 3-bit vector identifier. There are six sources: two external active-low pins, three timer overflow sources and one serial port source. The serial source combines a receive flag and a transmit flag. The third timer source combines an overflow flag and an external-event flag. Each source has its own enable bit, and a global enable gates all six. A priority register places each source at high or low level, and a fixed polling order breaks ties within a level.

The CPU takes the presented vector by pulsing `irq_ack` while `irq_req` is high. On that acknowledge the block clears the source flag according to that source's own rule, and it marks the level as in service. A high-level request can interrupt a low-level service. Nothing can interrupt a service at the same level or at a higher level. The `eos` strobe stands in for the end of a service routine and pops the innermost active level. Software reads and writes the enable, priority, flag and type registers through a simple byte-wide register port. A flag write has the same effect as a hardware event, so it can raise a request or cancel one.

Top module: `irq_ctrl2l`

## Requirements
- R1: After reset, all four registers (enable 0xA8, priority 0xB8, flags 0xC0, type 0xC8) read 0x00 and `irq_req` is low.
- R2: Enable register 0xA8 holds one enable per source at bits 0..5 (0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2). Bit 7 is the global enable, and while it is 0 no request is raised.
- R3: Priority register 0xB8 uses the same bit positions. A 1 puts the source at high level, and any enabled pending high-level source wins over every low-level source.
- R4: Within one level, the pending source with the lowest vector ID wins. The vector IDs are 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2.
- R5: When type bit 0 (ext0) or bit 1 (ext1) of register 0xC8 is 1, a falling edge on the pin sets the flag. The request is visible two clock edges after the pin falls, and an acknowledge of that vector clears the flag.
- R6: When the type bit is 0, the external flag equals the inverted pin, delayed by two edges. An acknowledge does not clear the flag.
- R7: A pulse on `tmr0_ovf` or `tmr1_ovf` sets flag bit 1 or flag bit 3, and an acknowledge of vector 1 or vector 3 clears that flag.
- R8: The serial source is pending when flag bit 4 (rx) or flag bit 5 (tx) is set. The timer2 source is pending when flag bit 6 (overflow) or flag bit 7 (external) is set. An acknowledge clears none of these four bits.
- R9: A write to flag register 0xC0 replaces the edge-mode and hardware-set flags. Writing a 1 raises a request, and writing a 0 cancels a pending one.
- R10: While a low-level service is active, a pending enabled high-level source raises `irq_req` with its vector.
- R11: No request is raised for a source whose level is already in service, or for any source while a high-level service is active. `eos` ends the innermost active service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_n | input | 1 | External request pin 0, active low |
| ext1_n | input | 1 | External request pin 1, active low |
| tmr0_ovf | input | 1 | Timer 0 rollover pulse |
| tmr1_ovf | input | 1 | Timer 1 rollover pulse |
| tmr2_ovf | input | 1 | Timer 2 rollover pulse |
| tmr2_ext | input | 1 | Timer 2 external event pulse |
| ser_rx | input | 1 | Serial receive-done pulse |
| ser_tx | input | 1 | Serial transmit-done pulse |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | 8 | Register address |
| sw_wdata | input | 8 | Register write data |
| sw_rdata | output | 8 | Register read data (combinational on sw_addr) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 3 | Vector ID of the winning source |
| irq_ack | input | 1 | CPU takes the presented vector |
| eos | input | 1 | End of the current service routine |

## Verification
Register writes, hardware pulses, `irq_ack` and `eos` all take effect at the first rising edge after they are driven. `irq_req` and `irq_vec` are combinational from the stored state, so these results are due one edge after the stimulus. External pins pass through a sampling register first, so their effect on `irq_req` is due at the second edge. The bench drives every input just after a falling edge and samples just after the next falling edge, or the one after that for pin stimulus. It first confirms that the result is not yet present one edge early.

// File: rtl/irq_ctrl2l.sv
module irq_ctrl2l #(
  parameter logic [7:0] A_EN  = 8'hA8,
  parameter logic [7:0] A_PRI = 8'hB8,
  parameter logic [7:0] A_FLG = 8'hC0,
  parameter logic [7:0] A_TYP = 8'hC8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext0_n,
  input  logic       ext1_n,
  input  logic       tmr0_ovf,
  input  logic       tmr1_ovf,
  input  logic       tmr2_ovf,
  input  logic       tmr2_ext,
  input  logic       ser_rx,
  input  logic       ser_tx,
  input  logic       sw_wr,
  input  logic [7:0] sw_addr,
  input  logic [7:0] sw_wdata,
  output logic [7:0] sw_rdata,
  output logic       irq_req,
  output logic [2:0] irq_vec,
  input  logic       irq_ack,
  input  logic       eos
);

  logic [7:0] en_r, flg, flg_nxt;
  logic [5:0] pri_r, pend, hi, lo;
  logic [1:0] typ_r, pin_q, pin_qq, fall;
  logic       hi_act, lo_act, sel_hi, sel_lo, take;
  logic [7:0] clr;

  function automatic logic [2:0] first_set(input logic [5:0] v);
    first_set = 3'd0;
    for (int i = 5; i >= 0; i--)
      if (v[i]) first_set = 3'(i);
  endfunction

  // pin sampling and edge detect
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_q  <= 2'b11;
      pin_qq <= 2'b11;
    end else begin
      pin_q  <= {ext1_n, ext0_n};
      pin_qq <= pin_q;
    end

  assign fall = pin_qq & ~pin_q;

  // arbitration
  assign pend = {flg[6] | flg[7], flg[4] | flg[5], flg[3:0]} & en_r[5:0] & {6{en_r[7]}};
  assign hi     = pend & pri_r;
  assign lo     = pend & ~pri_r;
  assign sel_hi = (|hi) && !hi_act;
  assign sel_lo = !sel_hi && (|lo) && !hi_act && !lo_act;
  assign irq_req = sel_hi | sel_lo;
  assign irq_vec = sel_hi ? first_set(hi) : first_set(lo);
  assign take    = irq_ack && irq_req;

  // flag clear rules on acknowledge
  always_comb begin
    clr = '0;
    if (take)
      case (irq_vec)
        3'd0:    clr[0] = typ_r[0];
        3'd1:    clr[1] = 1'b1;
        3'd2:    clr[2] = typ_r[1];
        3'd3:    clr[3] = 1'b1;
        default: clr = '0;
      endcase
  end

  always_comb begin
    flg_nxt = flg & ~clr;
    flg_nxt[0] = flg_nxt[0] | fall[0];
    flg_nxt[2] = flg_nxt[2] | fall[1];
    flg_nxt[1] = flg_nxt[1] | tmr0_ovf;
    flg_nxt[3] = flg_nxt[3] | tmr1_ovf;
    flg_nxt[4] = flg_nxt[4] | ser_rx;
    flg_nxt[5] = flg_nxt[5] | ser_tx;
    flg_nxt[6] = flg_nxt[6] | tmr2_ovf;
    flg_nxt[7] = flg_nxt[7] | tmr2_ext;
    if (sw_wr && sw_addr == A_FLG) flg_nxt = sw_wdata;
    if (!typ_r[0]) flg_nxt[0] = ~pin_q[0];
    if (!typ_r[1]) flg_nxt[2] = ~pin_q[1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flg   <= '0;
      en_r  <= '0;
      pri_r <= '0;
      typ_r <= '0;
    end else begin
      flg <= flg_nxt;
      if (sw_wr && sw_addr == A_EN)  en_r  <= sw_wdata & 8'hBF;
      if (sw_wr && sw_addr == A_PRI) pri_r <= sw_wdata[5:0];
      if (sw_wr && sw_addr == A_TYP) typ_r <= sw_wdata[1:0];
    end

  // in-service levels
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_act <= 1'b0;
      lo_act <= 1'b0;
    end else begin
      if (eos) begin
        if (hi_act) hi_act <= 1'b0;
        else        lo_act <= 1'b0;
      end
      if (take) begin
        if (sel_hi) hi_act <= 1'b1;
        else        lo_act <= 1'b1;
      end
    end

  always_comb
    case (sw_addr)
      A_EN:    sw_rdata = en_r;
      A_PRI:   sw_rdata = {2'b00, pri_r};
      A_FLG:   sw_rdata = flg;
      A_TYP:   sw_rdata = {6'd0, typ_r};
      default: sw_rdata = 8'h00;
    endcase

  // assertions
  assert_vec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec <= 3'd5);

  assert_global_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_r[7] |-> !irq_req);

  assert_hi_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hi_act |-> !irq_req);

  assert_tmr0_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vec == 3'd1 && !tmr0_ovf && !(sw_wr && sw_addr == A_FLG)) |=> !flg[1]);

  assert_serial_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vec == 3'd4 && !(sw_wr && sw_addr == A_FLG)) |=> (flg[4] | flg[5]));

  assert_take_sets_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eos) |=> (hi_act || lo_act));

endmodule

// File: tb/tb_irq_ctrl2l.sv
module tb_irq_ctrl2l;
  logic clk = 0, rst_n = 0;
  logic ext0_n = 1, ext1_n = 1;
  logic tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, tmr2_ext = 0, ser_rx = 0, ser_tx = 0;
  logic sw_wr = 0;
  logic [7:0] sw_addr = 0, sw_wdata = 0, sw_rdata;
  logic irq_req, irq_ack = 0, eos = 0;
  logic [2:0] irq_vec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_ctrl2l dut (.*);

  // {en, pri, flags, req, vec}
  localparam logic [27:0] TV [10] = '{
    {8'h3F, 8'h00, 8'hFF, 1'b0, 3'd0},
    {8'hBF, 8'h00, 8'hFF, 1'b1, 3'd0},
    {8'hBF, 8'h20, 8'hFF, 1'b1, 3'd5},
    {8'hBF, 8'h0C, 8'hFF, 1'b1, 3'd2},
    {8'hBE, 8'h00, 8'h03, 1'b1, 3'd1},
    {8'hB0, 8'h00, 8'h20, 1'b1, 3'd4},
    {8'hA0, 8'h00, 8'h80, 1'b1, 3'd5},
    {8'h9F, 8'h00, 8'h40, 1'b0, 3'd0},
    {8'h88, 8'h08, 8'h08, 1'b1, 3'd3},
    {8'hBF, 8'h00, 8'h00, 1'b0, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input logic r, input logic [2:0] v);
    chk({tag, " req"}, int'(irq_req), int'(r));
    if (r) chk({tag, " vec"}, int'(irq_vec), int'(v));
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [7:0] e);
    sw_addr = a;
    #1;
    chk(tag, int'(sw_rdata), int'(e));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sw_wr = 1; sw_addr = a; sw_wdata = d;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic pop();
    @(negedge clk); eos = 1;
    @(negedge clk); eos = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_reg("R1 en", 8'hA8, 8'h00);
    chk_reg("R1 pri", 8'hB8, 8'h00);
    chk_reg("R1 flg", 8'hC0, 8'h00);
    chk_reg("R1 typ", 8'hC8, 8'h00);
    chk("R1 irq_req", int'(irq_req), 0);

    // table: R2 R3 R4 R8 R9
    wr(8'hC8, 8'h03);
    for (int i = 0; i < 10; i++) begin
      wr(8'hA8, TV[i][27:20]);
      wr(8'hB8, TV[i][19:12]);
      wr(8'hC0, TV[i][11:4]);
      chk_irq($sformatf("R2/R3/R4/R9 row %0d", i), TV[i][3], TV[i][2:0]);
    end

    // R5 edge mode ext0
    wr(8'hA8, 8'h81); wr(8'hB8, 8'h00);
    @(negedge clk); ext0_n = 0;
    @(negedge clk); chk_irq("R5 early", 0, 0);
    @(negedge clk); chk_irq("R5 edge", 1, 3'd0);
    ext0_n = 1;
    ack();
    chk_reg("R5 cleared", 8'hC0, 8'h00);
    chk_irq("R5 after ack", 0, 0);
    pop();

    // R6 level mode ext1
    wr(8'hC8, 8'h00); wr(8'hA8, 8'h84);
    @(negedge clk); ext1_n = 0;
    @(negedge clk); chk_irq("R6 early", 0, 0);
    @(negedge clk); chk_irq("R6 level", 1, 3'd2);
    ack();
    chk_reg("R6 kept", 8'hC0, 8'h04);
    chk_irq("R11 lo busy", 0, 0);
    pop();
    chk_irq("R11 after eos", 1, 3'd2);
    ext1_n = 1;
    @(negedge clk); @(negedge clk);
    chk_reg("R6 follows pin", 8'hC0, 8'h00);
    chk_irq("R6 released", 0, 0);

    // R7 timer0
    wr(8'hA8, 8'h82);
    @(negedge clk); tmr0_ovf = 1;
    @(negedge clk); tmr0_ovf = 0;
    chk_irq("R7 set", 1, 3'd1);
    ack();
    chk_reg("R7 cleared", 8'hC0, 8'h00);
    pop();

    // R8 serial
    wr(8'hA8, 8'h90);
    @(negedge clk); ser_tx = 1;
    @(negedge clk); ser_tx = 0;
    chk_irq("R8 serial", 1, 3'd4);
    ack();
    chk_reg("R8 tx kept", 8'hC0, 8'h20);
    pop();
    chk_irq("R8 still pending", 1, 3'd4);
    wr(8'hC0, 8'h00);
    chk_irq("R9 cancel", 0, 0);

    // R8 timer2
    wr(8'hA8, 8'hA0);
    @(negedge clk); tmr2_ext = 1;
    @(negedge clk); tmr2_ext = 0;
    chk_irq("R8 t2", 1, 3'd5);
    ack();
    chk_reg("R8 t2 kept", 8'hC0, 8'h80);
    pop();
    wr(8'hC0, 8'h00);

    // R10 / R11 nesting
    wr(8'hC8, 8'h03); wr(8'hA8, 8'hBF); wr(8'hB8, 8'h02);
    wr(8'hC0, 8'h10);
    chk_irq("R10 low", 1, 3'd4);
    ack();
    chk_irq("R11 low busy", 0, 0);
    wr(8'hC0, 8'h12);
    chk_irq("R10 preempt", 1, 3'd1);
    ack();
    chk_reg("R7 nested clear", 8'hC0, 8'h10);
    wr(8'hC0, 8'h12);
    chk_irq("R11 hi busy", 0, 0);
    pop();
    chk_irq("R11 hi popped", 1, 3'd1);
    wr(8'hC0, 8'h10);
    chk_irq("R11 lo still busy", 0, 0);
    pop();
    chk_irq("R11 lo popped", 1, 3'd4);
    wr(8'hC0, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule